// File: doc/BRIEF.md
# Background Tile Row Fetcher

This block reads one row of eight pixels from a background or window tile and hands it to the background pixel queue. Each row takes four steps. The first step reads the tile number from the tile map. The next two steps read the low and then the high bitplane byte of the selected row from tile data. The last step offers both bytes to the queue and holds them until the queue takes them. The three read steps each last two dots, and the memory read happens on the second dot.

The fetcher keeps its own horizontal position. A restart pulse loads that position, for example at the start of a line or when the window begins. After each accepted row the position moves on by eight pixels. Scroll, line and control inputs are sampled again at every read and never held across tiles, so a change made between tiles or between bitplanes takes effect at the next read. The queue itself and object fetching are handled elsewhere.

The push interface is valid/ready, and ready means "the background queue is empty". While `push_valid` is high and `push_ready` is low, the fetcher stalls in the push step. `push_lo` and `push_hi` stay unchanged during the stall. A row is transferred on a clock where both are high. A restart or a low `run` withdraws the offer.

Top module: `bgrow_fetch`

## Requirements
- R1: While `run` is high and no restart occurs, the fetcher repeats seven dots per row when the queue is ready. The read pulses fall on dots 2, 4 and 6 of the row: the tile map first, then the low bitplane (address bit 0 = 0), then the high bitplane (address bit 0 = 1). The push is offered on dot 7. `mem_rd` is never high on two dots in a row.
- R2: `push_valid` stays high, with `push_lo`/`push_hi` stable, until `push_ready` is high on a clock. Exceptions: a restart or a low `run` ends the offer with no transfer.
- R3: A tile-map read in background mode uses this address:
  - bits 15..11 = 10011
  - bit 10 = `ctl_map_bg`
  - bits 9..5 = ((`line_y`+`scroll_y`) mod 256)/8
  - bits 4..0 = ((X+`scroll_x`) mod 256)/8, where X is the internal horizontal position
- R4: A tile-map read in window mode (`win_mode`=1) uses this address:
  - bits 15..11 = 10011
  - bit 10 = `ctl_map_win`
  - bits 9..5 = `win_line`/8
  - bits 4..0 = X/8
- R5: A bitplane read uses this address:
  - bits 15..13 = 100
  - bit 12 = NOT(`ctl_data_sel` OR tile number bit 7)
  - bits 11..4 = the tile number read in the same row
  - bits 3..1 = row
  - bit 0 = plane
- R6: The row is (`line_y`+`scroll_y`) mod 8 in background mode and `win_line` mod 8 in window mode.
- R7: When `attr_vflip` is 1 at a bitplane read, address bits 3..1 carry the inverted row.
- R8: When `attr_hflip` is 1 at a bitplane read, the byte stored for that plane is bit-reversed (bit 0 becomes bit 7). The tile number is never reversed.
- R9: Scroll, line, window and control inputs are taken at the read that uses them. A change between tiles or between the two bitplane reads shows in the next address.
- R10: A `restart` pulse has three effects:
  - it loads X from `restart_x` and sends the fetcher to the tile-map step on the next dot
  - it cancels any pending push
  - it drives `q_flush` high in that cycle when `run` is high
- R11: A read made while `mem_blocked` is high yields 0xFF in place of `mem_rdata`.
- R12: Each accepted push adds 8 to X, modulo 256.
- R13: After reset, or while `run` is low, `mem_rd` and `push_valid` are low and the next row starts at the tile-map step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Fetching enabled (pixel-transfer period) |
| restart | input | 1 | Pulse: reload X and restart at the tile-map step |
| restart_x | input | 8 | Horizontal position loaded by `restart` |
| win_mode | input | 1 | 1 = window addressing, 0 = background addressing |
| line_y | input | 8 | Current scanline |
| scroll_y | input | 8 | Vertical scroll |
| scroll_x | input | 8 | Horizontal scroll |
| win_line | input | 8 | Window line counter |
| ctl_map_bg | input | 1 | Tile-map select for background |
| ctl_map_win | input | 1 | Tile-map select for window |
| ctl_data_sel | input | 1 | Tile-data area select (1 = unsigned area) |
| attr_vflip | input | 1 | Vertical flip of the current tile |
| attr_hflip | input | 1 | Horizontal flip of the current tile |
| mem_rd | output | 1 | Read strobe, data returned in the same dot |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data |
| mem_blocked | input | 1 | Memory access blocked; read yields 0xFF |
| push_valid | output | 1 | Row offered to the background queue |
| push_ready | input | 1 | Background queue empty, accepts the row |
| push_lo | output | 8 | Low bitplane of the row |
| push_hi | output | 8 | High bitplane of the row |
| q_flush | output | 1 | Clear the background queue |

## Verification
A wrong step state shows at the ports within one to two dots: a read pulse appears on the wrong dot, two pulses appear back to back, or `push_valid` rises early. A wrong internal horizontal position or tile-number latch shows in the address of the very next tile-map or bitplane read. A wrong bitplane capture shows as wrong `push_lo`/`push_hi` at the next push dot. The bench therefore compares the read strobe and address, the push strobe and data, and the flush pulse against a reference on every dot.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  localparam int unsigned COORD_W  = 8;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned ADDR_W   = 16;
  localparam logic [4:0]  MAP_BASE = 5'b10011;
  localparam logic [2:0]  DAT_BASE = 3'b100;

  typedef enum logic [2:0] {
    ST_ID_A, ST_ID_B, ST_LO_A, ST_LO_B, ST_HI_A, ST_HI_B, ST_PUSH
  } step_t;

  function automatic logic is_read_step(step_t s);
    return (s == ST_ID_B) || (s == ST_LO_B) || (s == ST_HI_B);
  endfunction
endpackage

// File: rtl/bgf_seq.sv
module bgf_seq
  import bgf_pkg::*;
#(
  parameter int unsigned COORD_W = bgf_pkg::COORD_W,
  parameter int unsigned TILE_PX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [COORD_W-1:0] restart_x,
  input  logic               push_ready,
  output step_t              step,
  output logic [COORD_W-1:0] pos_x,
  output logic               push_valid,
  output logic               push_fire
);
  localparam logic [COORD_W-1:0] X_STEP = COORD_W'(TILE_PX);

  step_t step_nx;

  assign push_valid = run && !restart && (step == ST_PUSH);
  assign push_fire  = push_valid && push_ready;

  always_comb begin
    step_nx = step;
    if (restart || !run) begin
      step_nx = ST_ID_A;
    end else begin
      unique case (step)
        ST_ID_A: step_nx = ST_ID_B;
        ST_ID_B: step_nx = ST_LO_A;
        ST_LO_A: step_nx = ST_LO_B;
        ST_LO_B: step_nx = ST_HI_A;
        ST_HI_A: step_nx = ST_HI_B;
        ST_HI_B: step_nx = ST_PUSH;
        ST_PUSH: step_nx = push_ready ? ST_ID_A : ST_PUSH;
        default: step_nx = ST_ID_A;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step  <= ST_ID_A;
      pos_x <= '0;
    end else begin
      step <= step_nx;
      if (restart)        pos_x <= restart_x;
      else if (push_fire) pos_x <= pos_x + X_STEP;
    end
  end

  AST_X_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> (pos_x == $past(pos_x) + X_STEP));  // R12

  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid || restart || !run));  // R2

  AST_RESTART_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (step == ST_ID_A));  // R10
endmodule

// File: rtl/bgf_addr.sv
module bgf_addr
  import bgf_pkg::*;
#(
  parameter int unsigned COORD_W = bgf_pkg::COORD_W,
  parameter int unsigned DATA_W  = bgf_pkg::DATA_W,
  parameter int unsigned ADDR_W  = bgf_pkg::ADDR_W
) (
  input  step_t              step,
  input  logic [COORD_W-1:0] pos_x,
  input  logic               win_mode,
  input  logic [COORD_W-1:0] line_y,
  input  logic [COORD_W-1:0] scroll_y,
  input  logic [COORD_W-1:0] scroll_x,
  input  logic [COORD_W-1:0] win_line,
  input  logic               ctl_map_bg,
  input  logic               ctl_map_win,
  input  logic               ctl_data_sel,
  input  logic               vflip,
  input  logic [DATA_W-1:0]  tile_id,
  output logic [ADDR_W-1:0]  addr
);
  localparam int unsigned ROW_W = $clog2(DATA_W);
  localparam int unsigned COL_W = COORD_W - ROW_W;

  logic [COORD_W-1:0] sum_y, sum_x;
  logic [COL_W-1:0]   map_row, map_col;
  logic               map_sel;
  logic [ROW_W-1:0]   row_raw, row_eff;
  logic               plane;
  logic               area_bit;
  logic [ADDR_W-1:0]  map_addr, dat_addr;

  assign sum_y = line_y + scroll_y;
  assign sum_x = pos_x + scroll_x;

  always_comb begin
    if (win_mode) begin
      map_sel = ctl_map_win;
      map_row = win_line[COORD_W-1:ROW_W];
      map_col = pos_x[COORD_W-1:ROW_W];
      row_raw = win_line[ROW_W-1:0];
    end else begin
      map_sel = ctl_map_bg;
      map_row = sum_y[COORD_W-1:ROW_W];
      map_col = sum_x[COORD_W-1:ROW_W];
      row_raw = sum_y[ROW_W-1:0];
    end
  end

  assign row_eff  = vflip ? ~row_raw : row_raw;
  assign plane    = (step == ST_HI_A) || (step == ST_HI_B);
  assign area_bit = ~(ctl_data_sel | tile_id[DATA_W-1]);

  assign map_addr = {MAP_BASE, map_sel, map_row, map_col};
  assign dat_addr = {DAT_BASE, area_bit, tile_id, row_eff, plane};

  assign addr = ((step == ST_ID_A) || (step == ST_ID_B)) ? map_addr : dat_addr;
endmodule

// File: rtl/bgf_rowbuf.sv
module bgf_rowbuf
  import bgf_pkg::*;
#(
  parameter int unsigned DATA_W = bgf_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  step_t             step,
  input  logic [DATA_W-1:0] rdata,
  input  logic              blocked,
  input  logic              hflip,
  output logic [DATA_W-1:0] tile_id,
  output logic [DATA_W-1:0] row_lo,
  output logic [DATA_W-1:0] row_hi
);
  logic [DATA_W-1:0] eff, eff_rev, plane_byte;

  assign eff = blocked ? {DATA_W{1'b1}} : rdata;

  for (genvar i = 0; i < DATA_W; i++) begin : g_rev
    assign eff_rev[i] = eff[DATA_W-1-i];
  end

  assign plane_byte = hflip ? eff_rev : eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_id <= '0;
      row_lo  <= '0;
      row_hi  <= '0;
    end else if (run) begin
      if (step == ST_ID_B) tile_id <= eff;
      if (step == ST_LO_B) row_lo  <= plane_byte;
      if (step == ST_HI_B) row_hi  <= plane_byte;
    end
  end

  AST_BLOCKED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == ST_LO_B && blocked) |=> (row_lo == {DATA_W{1'b1}}));  // R11
endmodule

// File: rtl/bgrow_fetch.sv
module bgrow_fetch
  import bgf_pkg::*;
#(
  parameter int unsigned COORD_W = bgf_pkg::COORD_W,
  parameter int unsigned DATA_W  = bgf_pkg::DATA_W,
  parameter int unsigned ADDR_W  = bgf_pkg::ADDR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [COORD_W-1:0] restart_x,
  input  logic               win_mode,
  input  logic [COORD_W-1:0] line_y,
  input  logic [COORD_W-1:0] scroll_y,
  input  logic [COORD_W-1:0] scroll_x,
  input  logic [COORD_W-1:0] win_line,
  input  logic               ctl_map_bg,
  input  logic               ctl_map_win,
  input  logic               ctl_data_sel,
  input  logic               attr_vflip,
  input  logic               attr_hflip,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [DATA_W-1:0]  mem_rdata,
  input  logic               mem_blocked,
  output logic               push_valid,
  input  logic               push_ready,
  output logic [DATA_W-1:0]  push_lo,
  output logic [DATA_W-1:0]  push_hi,
  output logic               q_flush
);
  step_t              step;
  logic [COORD_W-1:0] pos_x;
  logic [DATA_W-1:0]  tile_id;
  logic               push_fire;

  bgf_seq #(.COORD_W(COORD_W), .TILE_PX(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart),
    .restart_x(restart_x), .push_ready(push_ready), .step(step),
    .pos_x(pos_x), .push_valid(push_valid), .push_fire(push_fire)
  );

  bgf_addr #(.COORD_W(COORD_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_addr (
    .step(step), .pos_x(pos_x), .win_mode(win_mode), .line_y(line_y),
    .scroll_y(scroll_y), .scroll_x(scroll_x), .win_line(win_line),
    .ctl_map_bg(ctl_map_bg), .ctl_map_win(ctl_map_win),
    .ctl_data_sel(ctl_data_sel), .vflip(attr_vflip), .tile_id(tile_id),
    .addr(mem_addr)
  );

  bgf_rowbuf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .run(run), .step(step), .rdata(mem_rdata),
    .blocked(mem_blocked), .hflip(attr_hflip), .tile_id(tile_id),
    .row_lo(push_lo), .row_hi(push_hi)
  );

  assign mem_rd  = run && is_read_step(step);
  assign q_flush = run && restart;

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);  // R1

  AST_MAP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && step == ST_ID_B) |-> (mem_addr[ADDR_W-1 -: 5] == MAP_BASE));  // R3

  AST_DATA_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && step != ST_ID_B) |-> (mem_addr[ADDR_W-1 -: 3] == DAT_BASE));  // R5

  AST_HIGH_PLANE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && step == ST_HI_B) |-> mem_addr[0]);  // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!mem_rd && !push_valid));  // R13
endmodule

// File: tb/bgrow_fetch_tb.sv
`timescale 1ns/1ps
module bgrow_fetch_tb;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, run, restart, win_mode;
  logic [7:0] restart_x, line_y, scroll_y, scroll_x, win_line;
  logic ctl_map_bg, ctl_map_win, ctl_data_sel, attr_vflip, attr_hflip;
  logic mem_rd, mem_blocked, push_valid, push_ready, q_flush;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata, push_lo, push_hi;

  bgrow_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .restart(restart), .restart_x(restart_x),
    .win_mode(win_mode), .line_y(line_y), .scroll_y(scroll_y), .scroll_x(scroll_x),
    .win_line(win_line), .ctl_map_bg(ctl_map_bg), .ctl_map_win(ctl_map_win),
    .ctl_data_sel(ctl_data_sel), .attr_vflip(attr_vflip), .attr_hflip(attr_hflip),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_blocked(mem_blocked), .push_valid(push_valid), .push_ready(push_ready),
    .push_lo(push_lo), .push_hi(push_hi), .q_flush(q_flush)
  );

  function automatic logic [7:0] mem_fn(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign mem_rdata = mem_fn(mem_addr);

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  int checks = 0, fails = 0, cycles = 0;
  string cur_req = "R13";

  // reference state
  int ph = 0;
  logic [7:0] m_x = 0, m_tid = 0, m_lo = 0, m_hi = 0;

  function automatic logic [15:0] exp_addr();
    logic [7:0] sy, sx;
    logic [2:0] row;
    logic [15:0] a;
    sy = line_y + scroll_y;
    sx = m_x + scroll_x;
    if (ph <= 1) begin
      if (win_mode) a = {5'b10011, ctl_map_win, win_line[7:3], m_x[7:3]};
      else          a = {5'b10011, ctl_map_bg, sy[7:3], sx[7:3]};
    end else begin
      row = win_mode ? win_line[2:0] : sy[2:0];
      if (attr_vflip) row = ~row;
      a = {3'b100, ~(ctl_data_sel | m_tid[7]), m_tid, row, (ph >= 4) ? 1'b1 : 1'b0};
    end
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_x = 0; m_tid = 0; m_lo = 0; m_hi = 0;
    end else begin
      logic [7:0] e;
      e = mem_blocked ? 8'hFF : mem_fn(exp_addr());
      if (run) begin
        if (ph == 1) m_tid = e;
        if (ph == 3) m_lo = attr_hflip ? rev8(e) : e;
        if (ph == 5) m_hi = attr_hflip ? rev8(e) : e;
      end
      if (restart) begin ph = 0; m_x = restart_x; end
      else if (!run) ph = 0;
      else if (ph == 6) begin
        if (push_ready) begin ph = 0; m_x = m_x + 8; end
      end else ph = ph + 1;
    end
  end

  always @(negedge clk) begin
    logic e_rd, e_pv, e_fl;
    e_rd = rst_n && run && (ph == 1 || ph == 3 || ph == 5);
    e_pv = rst_n && run && !restart && ph == 6;
    e_fl = run && restart;
    checks++;
    if (mem_rd !== e_rd || push_valid !== e_pv || q_flush !== e_fl) begin
      fails++;
      $display("FAIL %s strobes rd/pv/fl actual %b%b%b expected %b%b%b at %0t",
               cur_req, mem_rd, push_valid, q_flush, e_rd, e_pv, e_fl, $time);
    end else if (e_rd && mem_addr !== exp_addr()) begin
      fails++;
      $display("FAIL %s mem_addr actual %h expected %h at %0t",
               cur_req, mem_addr, exp_addr(), $time);
    end else if (e_pv && (push_lo !== m_lo || push_hi !== m_hi)) begin
      fails++;
      $display("FAIL %s push data actual %h/%h expected %h/%h at %0t",
               cur_req, push_lo, push_hi, m_lo, m_hi, $time);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog actual %0d expected <20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_restart(input logic [7:0] x);
    restart = 1; restart_x = x;
    step_n(1);
    restart = 0;
  endtask

  initial begin
    rst_n = 0; run = 0; restart = 0; restart_x = 0; win_mode = 0;
    line_y = 8'h40; scroll_y = 8'h25; scroll_x = 8'h13; win_line = 8'h1D;
    ctl_map_bg = 0; ctl_map_win = 1; ctl_data_sel = 0;
    attr_vflip = 0; attr_hflip = 0; mem_blocked = 0; push_ready = 1;
    step_n(3);
    rst_n = 1;
    step_n(2);               // R13: idle after reset
    cur_req = "R1"; run = 1;
    pulse_restart(8'h00);
    step_n(30);              // R1, R3, R12 background rows
    cur_req = "R2"; push_ready = 0;
    step_n(12);
    push_ready = 1; step_n(9);
    cur_req = "R9"; scroll_x = 8'hF7; ctl_map_bg = 1; step_n(4);
    scroll_y = 8'h03; line_y = 8'h91; step_n(10);
    cur_req = "R5"; ctl_data_sel = 1; step_n(21);
    ctl_data_sel = 0; step_n(21);
    cur_req = "R10"; push_ready = 0; step_n(8);
    win_mode = 1; pulse_restart(8'h00);  // window trigger cancels pending push
    push_ready = 1;
    cur_req = "R4"; step_n(21);
    cur_req = "R6"; win_line = 8'h2E; step_n(14);
    cur_req = "R7"; attr_vflip = 1; step_n(14);
    cur_req = "R8"; attr_hflip = 1; step_n(14);
    attr_vflip = 0; win_mode = 0; step_n(14);
    attr_hflip = 0;
    cur_req = "R11"; mem_blocked = 1; step_n(14);
    mem_blocked = 0; step_n(7);
    cur_req = "R12"; pulse_restart(8'hF0); step_n(35);
    cur_req = "R13"; run = 0; step_n(10);
    run = 1; step_n(14);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule